// File: doc/BRIEF.md
# Fibonacci LFSR with Zero-State Escape

This block is a 32-stage Fibonacci linear feedback shift register that serves as a pseudo-random bit source. On every clock edge all stages move one place toward the high end. The first stage is filled from one of three feed sources, chosen each cycle by a small combinational selector:

- **SRC_TAPS:** the XOR of four tapped stages.
- **SRC_MANUAL:** a serial bit supplied by the user.
- **SRC_KICK:** a forced one, used when the whole register is zero.

The selector moves between these sources as follows:

- **SRC_TAPS to SRC_KICK:** taken whenever manual mode is off and every stage is zero.
- **SRC_KICK to SRC_TAPS:** taken once a non-zero value appears.
- **Into SRC_MANUAL:** any source moves here while the select input is high.
- **Out of SRC_MANUAL:** the source returns to SRC_TAPS or SRC_KICK when the select input goes low.

The eight highest stages leave the block as a parallel byte.

To start the register from a known point, hold manual mode with a zero data bit for at least 32 clocks, or pulse the synchronous reset. Then leave manual mode. The zero-state escape inserts a single one, which walks to the output byte before the feedback pattern builds up.

Top module: `lfsr_byte_gen`

## Requirements
- R1: The register holds 32 stages, numbered 1 to 32. `tap_byte_o` bit k shows stage 25+k: bit 0 is stage 25 and bit 7 is stage 32.
- R2: On each rising clock edge with `rst_ni` high, stage n (n = 2..32) takes the previous value of stage n-1.
- R3: With `manual_sel_i` = 0 and a non-zero register, stage 1 takes the XOR of stages 25, 26, 30 and 32.
- R4: With `manual_sel_i` = 1, stage 1 takes `manual_bit_i`, whatever the register holds.
- R5: With `manual_sel_i` = 0 and all 32 stages at zero, stage 1 is loaded with 1.
- R6: A rising edge with `rst_ni` = 0 clears all 32 stages, regardless of the other inputs.
- R7: Starting from all zeros in feedback mode, the byte reads 0 after edges 1 to 24. It reads 8'h01 after edge 25 and then doubles on each edge, up to 8'h80 after edge 32.
- R8: In manual mode with `manual_bit_i` = 0, an all-zero register stays all zero on every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Synchronous reset, active low; clears all stages |
| manual_sel_i | input | 1 | 1 selects the manual bit as the stage-1 feed; 0 selects the feedback |
| manual_bit_i | input | 1 | Serial bit loaded into stage 1 in manual mode |
| tap_byte_o | output | 8 | Stages 25 (bit 0) to 32 (bit 7) |

## Verification
The bound checker checks every cycle that the stages shift by one, that stage 1 receives the bit the active source dictates, and that reset leaves zeros. This covers the tap XOR, the manual load and the zero-state kick. The bench's scenarios show what only long runs reveal. These include the walking one that follows an all-zero start, a manual word reaching the byte 32 edges later, the zero hold in manual mode, and more than a thousand consecutive bytes matching a model computed in the bench.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

    // Register length and the width of the exposed top slice
    localparam int unsigned LFSR_WIDTH = 32;
    localparam int unsigned LFSR_OUT_W = 8;

    // Taps at stages 32, 30, 26, 25 -> bit indices 31, 29, 25, 24
    localparam logic [LFSR_WIDTH-1:0] LFSR_TAPS = 32'hA300_0000;

    // Source that feeds stage 1 in a given cycle
    typedef enum logic [1:0] {
        SRC_TAPS   = 2'd0,
        SRC_MANUAL = 2'd1,
        SRC_KICK   = 2'd2
    } feed_src_e;

endpackage

// File: rtl/lfsr_feedback.sv
module lfsr_feedback #(
    parameter int unsigned               WIDTH    = lfsr_pkg::LFSR_WIDTH,
    parameter logic [WIDTH-1:0]          TAP_MASK = lfsr_pkg::LFSR_TAPS
) (
    input  logic [WIDTH-1:0] stage_i,
    output logic             tap_bit_o,
    output logic             all_zero_o
);

    logic [WIDTH-1:0] picked;

    // Keep only the tapped stages; the others contribute zero
    for (genvar g = 0; g < WIDTH; g++) begin : g_pick
        if (TAP_MASK[g]) begin : g_tap
            assign picked[g] = stage_i[g];
        end else begin : g_skip
            assign picked[g] = 1'b0;
        end
    end

    assign tap_bit_o  = ^picked;
    assign all_zero_o = (stage_i == '0);

endmodule

// File: rtl/lfsr_src_mux.sv
module lfsr_src_mux
    import lfsr_pkg::*;
(
    input  logic manual_sel_i,
    input  logic manual_bit_i,
    input  logic tap_bit_i,
    input  logic all_zero_i,
    output logic feed_bit_o
);

    feed_src_e src;

    // Manual mode outranks the zero guard, so init can hold zeros
    always_comb begin
        if (manual_sel_i) begin
            src = SRC_MANUAL;
        end else if (all_zero_i) begin
            src = SRC_KICK;
        end else begin
            src = SRC_TAPS;
        end
    end

    always_comb begin
        unique case (src)
            SRC_MANUAL: feed_bit_o = manual_bit_i;
            SRC_KICK:   feed_bit_o = 1'b1;
            SRC_TAPS:   feed_bit_o = tap_bit_i;
            default:    feed_bit_o = tap_bit_i;
        endcase
    end

endmodule

// File: rtl/lfsr_chain.sv
module lfsr_chain #(
    parameter int unsigned WIDTH = lfsr_pkg::LFSR_WIDTH
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             feed_bit_i,
    output logic [WIDTH-1:0] stage_o
);

    logic [WIDTH:0] link;

    assign link[0] = feed_bit_i;

    // One flop per stage; each takes its lower neighbour
    for (genvar g = 0; g < WIDTH; g++) begin : g_stage
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                link[g+1] <= 1'b0;
            end else begin
                link[g+1] <= link[g];
            end
        end
    end

    assign stage_o = link[WIDTH:1];

endmodule

// File: rtl/lfsr_byte_gen.sv
module lfsr_byte_gen #(
    parameter int unsigned      WIDTH    = lfsr_pkg::LFSR_WIDTH,
    parameter int unsigned      OUT_W    = lfsr_pkg::LFSR_OUT_W,
    parameter logic [WIDTH-1:0] TAP_MASK = lfsr_pkg::LFSR_TAPS
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             manual_sel_i,
    input  logic             manual_bit_i,
    output logic [OUT_W-1:0] tap_byte_o
);

    localparam int unsigned OUT_LO = WIDTH - OUT_W;

    logic [WIDTH-1:0] stage_q;
    logic             tap_bit;
    logic             all_zero;
    logic             feed_bit;

    lfsr_feedback #(
        .WIDTH    (WIDTH),
        .TAP_MASK (TAP_MASK)
    ) feedback_i (
        .stage_i    (stage_q),
        .tap_bit_o  (tap_bit),
        .all_zero_o (all_zero)
    );

    lfsr_src_mux src_mux_i (
        .manual_sel_i (manual_sel_i),
        .manual_bit_i (manual_bit_i),
        .tap_bit_i    (tap_bit),
        .all_zero_i   (all_zero),
        .feed_bit_o   (feed_bit)
    );

    lfsr_chain #(
        .WIDTH (WIDTH)
    ) chain_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .feed_bit_i (feed_bit),
        .stage_o    (stage_q)
    );

    assign tap_byte_o = stage_q[WIDTH-1:OUT_LO];

endmodule

// File: rtl/lfsr_byte_gen_checker.sv
module lfsr_byte_gen_checker #(
    parameter int unsigned      WIDTH    = lfsr_pkg::LFSR_WIDTH,
    parameter logic [WIDTH-1:0] TAP_MASK = lfsr_pkg::LFSR_TAPS
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             manual_sel_i,
    input logic             manual_bit_i,
    input logic [WIDTH-1:0] stage_i
);

    assert_shift_up_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (stage_i[WIDTH-1:1] == $past(stage_i[WIDTH-2:0])));

    assert_tap_feed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!manual_sel_i && stage_i != '0) |=> (stage_i[0] == ^($past(stage_i) & TAP_MASK)));

    assert_manual_feed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        manual_sel_i |=> (stage_i[0] == $past(manual_bit_i)));

    assert_zero_kick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!manual_sel_i && stage_i == '0) |=> (stage_i == {{(WIDTH-1){1'b0}}, 1'b1}));

    assert_reset_clear_R6: assert property (@(posedge clk_i)
        !rst_ni |=> (stage_i == '0));

    assert_zero_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (manual_sel_i && !manual_bit_i && stage_i == '0) |=> (stage_i == '0));

endmodule

bind lfsr_byte_gen lfsr_byte_gen_checker #(
    .WIDTH    (WIDTH),
    .TAP_MASK (TAP_MASK)
) checker_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .manual_sel_i (manual_sel_i),
    .manual_bit_i (manual_bit_i),
    .stage_i      (stage_q)
);

// File: tb/lfsr_byte_gen_tb_top.sv
module lfsr_byte_gen_tb_top;

    localparam logic [31:0] MASK = 32'hA300_0000;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       manual_sel_i = 1'b0;
    logic       manual_bit_i = 1'b0;
    logic [7:0] tap_byte_o;

    int unsigned tests = 0;
    int unsigned fails = 0;
    logic [31:0] model = '0;

    always #4 clk_i = ~clk_i;

    lfsr_byte_gen dut_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .manual_sel_i (manual_sel_i),
        .manual_bit_i (manual_bit_i),
        .tap_byte_o   (tap_byte_o)
    );

    task automatic check(input string req, input logic [7:0] exp);
        tests++;
        if (tap_byte_o !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, tap_byte_o, exp);
        end
    endtask

    // One edge: drive inputs, advance the bench model, sample 1 ns later
    task automatic tick(input logic rst, input logic sel, input logic b);
        logic fb;
        rst_ni       = rst;
        manual_sel_i = sel;
        manual_bit_i = b;
        @(posedge clk_i);
        if (!rst) begin
            model = '0;
        end else begin
            if (sel)              fb = b;
            else if (model == '0) fb = 1'b1;
            else                  fb = ^(model & MASK);
            model = {model[30:0], fb};
        end
        #1;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] word;
        // R6: reset with manual ones pending still clears
        for (int i = 0; i < 4; i++) tick(1'b0, 1'b1, 1'b1);
        check("R6 reset clear", 8'h00);

        // R7/R5: walking one from the zero state
        for (int i = 1; i <= 32; i++) begin
            tick(1'b1, 1'b0, 1'b0);
            if (i <= 24)       check("R7 leading zeros", 8'h00);
            else               check("R7 walking one", 8'(1 << (i - 25)));
        end

        // R3/R2/R1: long feedback run against the bench model
        for (int i = 0; i < 1100; i++) begin
            tick(1'b1, 1'b0, 1'b0);
            check("R3 feedback sequence", model[31:24]);
        end

        // R4/R1: a manual word appears in the top byte after 32 edges
        word = 32'hC5A3_19E7;
        for (int i = 31; i >= 0; i--) tick(1'b1, 1'b1, word[i]);
        check("R4 manual word top byte", word[31:24]);
        for (int i = 0; i < 8; i++) begin
            tick(1'b1, 1'b1, 1'b0);
            check("R1 R2 manual shift", model[31:24]);
        end
        if (model[31:24] !== word[23:16]) begin
            fails++;
            $display("FAIL R4 bench model: got %h expected %h", model[31:24], word[23:16]);
        end

        // R8: manual zero fill then hold at zero
        for (int i = 0; i < 32; i++) tick(1'b1, 1'b1, 1'b0);
        check("R8 zero fill", 8'h00);
        for (int i = 0; i < 40; i++) begin
            tick(1'b1, 1'b1, 1'b0);
            check("R8 zero hold", 8'h00);
        end

        // R5/R7: leaving manual mode restarts the walking one
        for (int i = 1; i <= 25; i++) tick(1'b1, 1'b0, 1'b0);
        check("R5 kick after manual zeros", 8'h01);
        for (int i = 0; i < 200; i++) begin
            tick(1'b1, 1'b0, 1'b0);
            check("R3 feedback after restart", model[31:24]);
        end

        // R6: reset mid-run wins over the feed
        tick(1'b0, 1'b0, 1'b1);
        check("R6 reset mid-run", 8'h00);
        for (int i = 1; i <= 25; i++) tick(1'b1, 1'b0, 1'b0);
        check("R7 walking one after reset", 8'h01);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule